// File: doc/BRIEF.md
# Debug command decoder and sequencer

This block sits behind the shift logic of a serial debug port. Each time a 16-bit command word arrives with its strobe, the block works out which operation the word names. The possible operations are a core register access, a memory access, a block memory transfer, a control register access, a debug-module register access, a resume, or a null command. For each operation it also finds the access size and the register index. It then checks the operation against the processor run state. The result is one of three things, delivered one cycle later:

- a decoded-operation strobe to the bus and register access engine;
- an illegal-command response to the serializer;
- a not-ready response to the serializer.

Block memory transfers need state that lasts between commands. A memory read opens a read chain and a memory write opens a write chain. A continuation command of the matching kind and size then accesses the next address in the chain. The chain is held in a small three-state machine:

- `BLK_IDLE` means no chain is open.
- `BLK_RD` means a read chain is open.
- `BLK_WR` means a write chain is open.

The machine moves on every accepted command and on every not-ready command. The transitions are:

- `OPEN_RD`: a memory read moves the machine to `BLK_RD`.
- `OPEN_WR`: a memory write moves the machine to `BLK_WR`.
- `ADVANCE`: a matching continuation keeps the state and moves the address forward.
- `CLOSE`: any other command returns the machine to `BLK_IDLE`.

Illegal commands leave the machine untouched.

Top module: `dbg_cmd_seq`

## Requirements
- R1: While `rst_n` is low, `op_valid`, `rsp_illegal`, `rsp_notready` and `flush_req` are 0, and all operation fields are 0. After reset, no chain is open, so a continuation command is illegal until a memory read or write has been accepted.
- R2: Register words have the upper 12 bits 0x218 (read) or 0x208 (write). Their low 4 bits are copied to `op_reg` with a zero added on top. The kind is 2 for a read and 3 for a write.
- R2 (continued): Debug-module register words have the upper byte 0x2D (read) or 0x2C (write), and bits 7:5 must equal 100. Bits 4:0 are copied to `op_reg`. The kind is 10 for a read and 11 for a write.
- R3: Memory words are built from a base code plus a size offset. The base codes are 0x1900 for a read (kind 4), 0x1800 for a write (kind 5), 0x1D00 for a read continuation (kind 6) and 0x1C00 for a write continuation (kind 7). The size offsets are +0x00 for a byte, +0x40 for a word and +0x80 for a longword, and `op_size` gives 0, 1 or 2 to match. A memory read or write passes `cmd_addr` to `op_addr`.
- R4: The fixed codes are:
  - 0x0000, null command, kind 0;
  - 0x0C00, resume, kind 1;
  - 0x2980, control register read, kind 8;
  - 0x2880, control register write, kind 9.

  Control register accesses pass `cmd_addr` to `op_addr`.
- R5: Any word outside R2 to R4 raises `rsp_illegal` with no `op_valid` and leaves the chain state unchanged. Examples are a size offset of 0xC0, 0x2D00, 0xFFFF and 0x0001.
- R6: The halted-only commands are register accesses, control register accesses and resume. If one arrives while `cpu_halted` is 0, the block raises `rsp_notready`, gives no `op_valid` and closes any open chain.
- R7: Memory commands and debug-module or null commands are accepted whatever the value of `cpu_halted`.
- R8: A read continuation is accepted only while a read chain of the same size is open. The chain is opened by a memory read or a previous read continuation. The continuation's `op_addr` is the previous address plus 1, 2 or 4 for byte, word or longword.
- R9: A write continuation follows the same rule as R8, applied to an open write chain.
- R10: A continuation that has no matching open chain, or whose size differs from the chain's size, raises `rsp_illegal`.
- R11: Any command that is not illegal, and is not a memory read, write or continuation, closes the chain.
- R12: An accepted resume pulses `flush_req` for one cycle, together with `op_valid`.
- R13: All results appear in the cycle after the one in which `cmd_valid` is sampled high. At most one of `op_valid`, `rsp_illegal` and `rsp_notready` is high. All three are 0 in the cycle after `cmd_valid` was low. The operation fields are 0 whenever `op_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command word is presented this cycle |
| cmd_word | input | 16 | Deserialized command word |
| cmd_addr | input | ADDR_W | Address operand for memory read/write and control register access |
| cpu_halted | input | 1 | Processor is halted |
| op_valid | output | 1 | Decoded-operation strobe to the access engine |
| op_kind | output | 4 | Operation kind code (R2 to R4) |
| op_size | output | 2 | Access size: 0 byte, 1 word, 2 longword |
| op_reg | output | 5 | Register index |
| op_addr | output | ADDR_W | Access address |
| flush_req | output | 1 | Pipeline flush and refill request for resume |
| rsp_illegal | output | 1 | Illegal-command response |
| rsp_notready | output | 1 | Not-ready response |

## Verification
All outputs are registered. Each result is due exactly one clock edge after the edge that samples `cmd_valid` high, and it lasts for one cycle unless another command follows directly. The bench changes inputs on the falling edge. It reads the result on the next falling edge, which is half a period after the edge that registered it. It then reads again one falling edge later to confirm that the outputs have returned to idle. Chain effects are checked through the ports: a continuation is issued after the command under test, and its address or its response shows what chain state that command left behind.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam int REG_W = 5;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_GO    = 4'd1,
        OP_RREG  = 4'd2,
        OP_WREG  = 4'd3,
        OP_MRD   = 4'd4,
        OP_MWR   = 4'd5,
        OP_MDUMP = 4'd6,
        OP_MFILL = 4'd7,
        OP_RCTL  = 4'd8,
        OP_WCTL  = 4'd9,
        OP_RDBG  = 4'd10,
        OP_WDBG  = 4'd11
    } op_kind_e;

    typedef enum logic [1:0] {
        GATE_HALT  = 2'd0,
        GATE_STEAL = 2'd1,
        GATE_PAR   = 2'd2
    } gate_e;

    typedef enum logic [1:0] {
        BLK_IDLE = 2'd0,
        BLK_RD   = 2'd1,
        BLK_WR   = 2'd2
    } blk_state_e;

    typedef struct packed {
        logic             known;
        op_kind_e         kind;
        logic [1:0]       size;
        logic [REG_W-1:0] regsel;
        gate_e            gate;
    } dec_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
(
    input  logic [15:0] word,
    output dec_t        dec
);
    always_comb begin
        dec        = '0;
        dec.known  = 1'b0;
        dec.kind   = OP_NOP;
        dec.gate   = GATE_PAR;
        unique casez (word)
            16'h0000: begin
                dec.known = 1'b1;
                dec.kind  = OP_NOP;
                dec.gate  = GATE_PAR;
            end
            16'h0C00: begin
                dec.known = 1'b1;
                dec.kind  = OP_GO;
                dec.gate  = GATE_HALT;
            end
            16'b0010_000?_1000_????: begin
                dec.known  = 1'b1;
                dec.kind   = word[8] ? OP_RREG : OP_WREG;
                dec.regsel = {1'b0, word[3:0]};
                dec.gate   = GATE_HALT;
            end
            16'h2980: begin
                dec.known = 1'b1;
                dec.kind  = OP_RCTL;
                dec.gate  = GATE_HALT;
            end
            16'h2880: begin
                dec.known = 1'b1;
                dec.kind  = OP_WCTL;
                dec.gate  = GATE_HALT;
            end
            16'b0010_110?_????_????: begin
                if (word[7:5] == 3'b100) begin
                    dec.known  = 1'b1;
                    dec.kind   = word[8] ? OP_RDBG : OP_WDBG;
                    dec.regsel = word[4:0];
                    dec.gate   = GATE_PAR;
                end
            end
            16'b0001_1?0?_??00_0000: begin
                if (word[7:6] != 2'b11) begin
                    dec.known = 1'b1;
                    dec.size  = word[7:6];
                    dec.gate  = GATE_STEAL;
                    unique case ({word[10], word[8]})
                        2'b01:   dec.kind = OP_MRD;
                        2'b00:   dec.kind = OP_MWR;
                        2'b11:   dec.kind = OP_MDUMP;
                        default: dec.kind = OP_MFILL;
                    endcase
                end
            end
            default: dec.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbg_blk_tracker.sv
module dbg_blk_tracker
    import dbg_cmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  op_kind_e          kind,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              chain_ok,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    blk_state_e        state_q, state_d;
    logic [1:0]        size_q, size_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    assign next_addr = addr_q + (ONE << size_q);

    always_comb begin
        chain_ok = 1'b0;
        if (size == size_q) begin
            if (kind == OP_MDUMP && state_q == BLK_RD)
                chain_ok = 1'b1;
            if (kind == OP_MFILL && state_q == BLK_WR)
                chain_ok = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        size_d  = size_q;
        addr_d  = addr_q;
        if (upd) begin
            unique case (kind)
                OP_MRD: begin
                    state_d = BLK_RD;
                    size_d  = size;
                    addr_d  = base_addr;
                end
                OP_MWR: begin
                    state_d = BLK_WR;
                    size_d  = size;
                    addr_d  = base_addr;
                end
                OP_MDUMP, OP_MFILL: begin
                    addr_d  = next_addr;
                end
                default: begin
                    state_d = BLK_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BLK_IDLE;
            size_q  <= 2'd0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            size_q  <= size_d;
            addr_q  <= addr_d;
        end
    end
endmodule

// File: rtl/dbg_cmd_check.sv
module dbg_cmd_check
    import dbg_cmd_pkg::*;
(
    input  dec_t  dec,
    input  logic  chain_ok,
    input  logic  cpu_halted,
    output logic  illegal,
    output logic  notready,
    output logic  accept
);
    logic is_blk;

    assign is_blk   = (dec.kind == OP_MDUMP) || (dec.kind == OP_MFILL);
    assign illegal  = !dec.known || (is_blk && !chain_ok);
    assign notready = !illegal && (dec.gate == GATE_HALT) && !cpu_halted;
    assign accept   = !illegal && !notready;
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_cmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [15:0]       cmd_word,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cpu_halted,
    output logic              op_valid,
    output logic [3:0]        op_kind,
    output logic [1:0]        op_size,
    output logic [4:0]        op_reg,
    output logic [ADDR_W-1:0] op_addr,
    output logic              flush_req,
    output logic              rsp_illegal,
    output logic              rsp_notready
);
    dec_t              dec;
    logic              chain_ok;
    logic [ADDR_W-1:0] next_addr;
    logic              illegal, notready, accept;
    logic              upd;
    logic [ADDR_W-1:0] addr_sel;

    dbg_cmd_decode u_dec (
        .word (cmd_word),
        .dec  (dec)
    );

    dbg_cmd_check u_chk_gate (
        .dec        (dec),
        .chain_ok   (chain_ok),
        .cpu_halted (cpu_halted),
        .illegal    (illegal),
        .notready   (notready),
        .accept     (accept)
    );

    assign upd = cmd_valid && !illegal;

    dbg_blk_tracker #(.ADDR_W(ADDR_W)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .kind      (dec.kind),
        .size      (dec.size),
        .base_addr (cmd_addr),
        .chain_ok  (chain_ok),
        .next_addr (next_addr)
    );

    always_comb begin
        unique case (dec.kind)
            OP_MDUMP, OP_MFILL:              addr_sel = next_addr;
            OP_MRD, OP_MWR, OP_RCTL, OP_WCTL: addr_sel = cmd_addr;
            default:                         addr_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid     <= 1'b0;
            op_kind      <= 4'd0;
            op_size      <= 2'd0;
            op_reg       <= 5'd0;
            op_addr      <= '0;
            flush_req    <= 1'b0;
            rsp_illegal  <= 1'b0;
            rsp_notready <= 1'b0;
        end else begin
            op_valid     <= cmd_valid && accept;
            rsp_illegal  <= cmd_valid && illegal;
            rsp_notready <= cmd_valid && notready;
            flush_req    <= cmd_valid && accept && (dec.kind == OP_GO);
            if (cmd_valid && accept) begin
                op_kind <= dec.kind;
                op_size <= dec.size;
                op_reg  <= dec.regsel;
                op_addr <= addr_sel;
            end else begin
                op_kind <= 4'd0;
                op_size <= 2'd0;
                op_reg  <= 5'd0;
                op_addr <= '0;
            end
        end
    end
endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk
    import dbg_cmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [15:0]       cmd_word,
    input logic              cpu_halted,
    input logic              op_valid,
    input logic [3:0]        op_kind,
    input logic [ADDR_W-1:0] op_addr,
    input logic              flush_req,
    input logic              rsp_illegal,
    input logic              rsp_notready
);
    logic halt_kind;
    assign halt_kind = (op_kind == OP_GO)   || (op_kind == OP_RREG) ||
                       (op_kind == OP_WREG) || (op_kind == OP_RCTL) ||
                       (op_kind == OP_WCTL);

    assert_one_response_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_valid, rsp_illegal, rsp_notready}));

    assert_quiet_without_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !op_valid && !rsp_illegal && !rsp_notready);

    assert_notready_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_notready |-> !$past(cpu_halted));

    assert_halt_ops_need_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && halt_kind) |-> $past(cpu_halted));

    assert_flush_with_go_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> op_valid && op_kind == OP_GO);

    assert_unassigned_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word == 16'hFFFF) |=> rsp_illegal && !op_valid);

    assert_null_op_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == OP_NOP) |-> op_addr == '0);
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .cpu_halted   (cpu_halted),
    .op_valid     (op_valid),
    .op_kind      (op_kind),
    .op_addr      (op_addr),
    .flush_req    (flush_req),
    .rsp_illegal  (rsp_illegal),
    .rsp_notready (rsp_notready)
);

// File: tb/dbg_cmd_seq_test.sv
`timescale 1ns/1ps
module dbg_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic [31:0] cmd_addr;
    logic        cpu_halted;
    logic        op_valid;
    logic [3:0]  op_kind;
    logic [1:0]  op_size;
    logic [4:0]  op_reg;
    logic [31:0] op_addr;
    logic        flush_req;
    logic        rsp_illegal;
    logic        rsp_notready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dbg_cmd_seq #(.ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_addr(cmd_addr), .cpu_halted(cpu_halted), .op_valid(op_valid),
        .op_kind(op_kind), .op_size(op_size), .op_reg(op_reg), .op_addr(op_addr),
        .flush_req(flush_req), .rsp_illegal(rsp_illegal), .rsp_notready(rsp_notready)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [15:0] w, logic [31:0] a, logic h);
        @(negedge clk);
        cmd_word   = w;
        cmd_addr   = a;
        cpu_halted = h;
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic expect_op(string tag, logic [3:0] k, logic [1:0] s,
                             logic [4:0] r, logic [31:0] a);
        chk({tag, " op_valid"}, 32'(op_valid), 32'd1);
        chk({tag, " op_kind"}, 32'(op_kind), 32'(k));
        chk({tag, " op_size"}, 32'(op_size), 32'(s));
        chk({tag, " op_reg"}, 32'(op_reg), 32'(r));
        chk({tag, " op_addr"}, op_addr, a);
        chk({tag, " flush_req"}, 32'(flush_req), 32'(k == 4'd1));
        chk({tag, " responses"}, {30'd0, rsp_illegal, rsp_notready}, 32'd0);
    endtask

    task automatic expect_ill(string tag);
        chk({tag, " illegal"}, {29'd0, op_valid, rsp_illegal, rsp_notready}, 32'b010);
    endtask

    task automatic expect_nr(string tag);
        chk({tag, " notready"}, {29'd0, op_valid, rsp_illegal, rsp_notready}, 32'b001);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset outputs", {24'd0, op_valid, flush_req, rsp_illegal, rsp_notready,
            op_kind}, 32'd0);
        chk("R1 reset addr", op_addr, 32'd0);
        issue(16'h1D80, 32'h0, 1'b1);
        expect_ill("R1 dump right after reset");
    endtask

    task automatic t_regs;
        issue(16'h218B, 32'h0, 1'b1); expect_op("R2 read addr reg 3", 4'd2, 2'd0, 5'h0B, 32'h0);
        issue(16'h2085, 32'h0, 1'b1); expect_op("R2 write data reg 5", 4'd3, 2'd0, 5'h05, 32'h0);
        issue(16'h2D9F, 32'h0, 1'b0); expect_op("R2 debug reg read", 4'd10, 2'd0, 5'h1F, 32'h0);
        issue(16'h2C83, 32'h0, 1'b1); expect_op("R2 debug reg write", 4'd11, 2'd0, 5'h03, 32'h0);
    endtask

    task automatic t_mem;
        issue(16'h1900, 32'h1234, 1'b1); expect_op("R3 read byte", 4'd4, 2'd0, 5'd0, 32'h1234);
        issue(16'h1840, 32'h2000, 1'b1); expect_op("R3 write word", 4'd5, 2'd1, 5'd0, 32'h2000);
        issue(16'h1980, 32'hABCD0000, 1'b1); expect_op("R3 read long", 4'd4, 2'd2, 5'd0, 32'hABCD0000);
    endtask

    task automatic t_fixed;
        issue(16'h0000, 32'h55, 1'b1); expect_op("R4 null", 4'd0, 2'd0, 5'd0, 32'h0);
        issue(16'h2980, 32'h801, 1'b1); expect_op("R4 control read", 4'd8, 2'd0, 5'd0, 32'h801);
        issue(16'h2880, 32'h802, 1'b1); expect_op("R4 control write", 4'd9, 2'd0, 5'd0, 32'h802);
    endtask

    task automatic t_illegal;
        issue(16'h1980, 32'h100, 1'b1); expect_op("R5 open chain", 4'd4, 2'd2, 5'd0, 32'h100);
        issue(16'h19C0, 32'h0, 1'b1); expect_ill("R5 size offset C0");
        issue(16'h2D00, 32'h0, 1'b1); expect_ill("R5 bad fixed bits");
        issue(16'hFFFF, 32'h0, 1'b1); expect_ill("R5 all ones");
        issue(16'h0001, 32'h0, 1'b0); expect_ill("R5 0001");
        issue(16'h1D80, 32'h0, 1'b1); expect_op("R5 chain kept", 4'd6, 2'd2, 5'd0, 32'h104);
    endtask

    task automatic t_notready;
        issue(16'h1900, 32'h40, 1'b0); expect_op("R7 read while running", 4'd4, 2'd0, 5'd0, 32'h40);
        issue(16'h2181, 32'h0, 1'b0); expect_nr("R6 reg read running");
        issue(16'h1D00, 32'h0, 1'b0); expect_ill("R6 chain closed by notready");
        issue(16'h0C00, 32'h0, 1'b0); expect_nr("R6 resume running");
        issue(16'h2880, 32'h0, 1'b0); expect_nr("R6 control write running");
        issue(16'h0000, 32'h0, 1'b0); expect_op("R7 null running", 4'd0, 2'd0, 5'd0, 32'h0);
    endtask

    task automatic t_dump;
        issue(16'h1940, 32'h2000, 1'b0); expect_op("R8 read word", 4'd4, 2'd1, 5'd0, 32'h2000);
        issue(16'h1D40, 32'h0, 1'b0); expect_op("R8 dump 1", 4'd6, 2'd1, 5'd0, 32'h2002);
        issue(16'h1D40, 32'h0, 1'b1); expect_op("R8 dump 2", 4'd6, 2'd1, 5'd0, 32'h2004);
        issue(16'h1900, 32'hFFFFFFFF, 1'b1); expect_op("R8 read byte top", 4'd4, 2'd0, 5'd0, 32'hFFFFFFFF);
        issue(16'h1D00, 32'h0, 1'b1); expect_op("R8 dump wraps", 4'd6, 2'd0, 5'd0, 32'h0);
    endtask

    task automatic t_fill;
        issue(16'h1800, 32'h30, 1'b1); expect_op("R9 write byte", 4'd5, 2'd0, 5'd0, 32'h30);
        issue(16'h1C00, 32'h0, 1'b1); expect_op("R9 fill 1", 4'd7, 2'd0, 5'd0, 32'h31);
        issue(16'h1880, 32'h500, 1'b0); expect_op("R9 write long", 4'd5, 2'd2, 5'd0, 32'h500);
        issue(16'h1C80, 32'h0, 1'b0); expect_op("R9 fill long", 4'd7, 2'd2, 5'd0, 32'h504);
        issue(16'h1C80, 32'h0, 1'b0); expect_op("R9 fill long 2", 4'd7, 2'd2, 5'd0, 32'h508);
    endtask

    task automatic t_chain_bad;
        issue(16'h1900, 32'h700, 1'b1); expect_op("R10 read byte", 4'd4, 2'd0, 5'd0, 32'h700);
        issue(16'h1C00, 32'h0, 1'b1); expect_ill("R10 fill after read");
        issue(16'h1D40, 32'h0, 1'b1); expect_ill("R10 size mismatch");
        issue(16'h1D00, 32'h0, 1'b1); expect_op("R10 chain survives", 4'd6, 2'd0, 5'd0, 32'h701);
    endtask

    task automatic t_clear;
        issue(16'h1880, 32'h900, 1'b1); expect_op("R11 write long", 4'd5, 2'd2, 5'd0, 32'h900);
        issue(16'h2C80, 32'h0, 1'b1); expect_op("R11 debug write", 4'd11, 2'd0, 5'd0, 32'h0);
        issue(16'h1C80, 32'h0, 1'b1); expect_ill("R11 fill after close");
        issue(16'h1980, 32'hA00, 1'b1); expect_op("R11 read long", 4'd4, 2'd2, 5'd0, 32'hA00);
        issue(16'h1840, 32'hB00, 1'b1); expect_op("R11 write word", 4'd5, 2'd1, 5'd0, 32'hB00);
        issue(16'h1D80, 32'h0, 1'b1); expect_ill("R11 dump after write");
    endtask

    task automatic t_go;
        issue(16'h0C00, 32'h0, 1'b1); expect_op("R12 resume", 4'd1, 2'd0, 5'd0, 32'h0);
        chk("R12 flush pulse", 32'(flush_req), 32'd1);
        @(negedge clk);
        chk("R12 flush one cycle", 32'(flush_req), 32'd0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        cmd_word = 16'h0000; cmd_addr = 32'h0; cpu_halted = 1'b1; cmd_valid = 1'b1;
        #1;
        chk("R13 not before edge", 32'(op_valid), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R13 one cycle later", 32'(op_valid), 32'd1);
        @(negedge clk);
        chk("R13 idle after", {29'd0, op_valid, rsp_illegal, rsp_notready}, 32'd0);
        chk("R13 fields zero", {26'd0, op_kind, op_size}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = 16'h0; cmd_addr = 32'h0; cpu_halted = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {29'd0, op_valid, rsp_illegal, rsp_notready}, 32'd0);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_mem;
        t_fixed;
        t_illegal;
        t_notready;
        t_dump;
        t_fill;
        t_chain_bad;
        t_clear;
        t_go;
        t_timing;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule